// File: doc/BRIEF.md
# Dual-Agent Transfer Register File

This block is the staging store between an engine's execution datapath and the units outside the engine. It keeps four groups of 32-bit registers. Two groups are inbound: one for the shared bus and one for the memory bus. Outside units fill them, for example when read data comes back. The datapath reads them as instruction operands. The other two groups are outbound. The datapath fills them with results, and outside units collect them.

A datapath access names its register in one of two ways. It can take the slot number from the instruction field. It can instead take it from a single index register that the datapath loads. An indirect access may also ask for the index to step forward afterwards. The step wraps inside the group. Every port picks its group with a one-bit set code: 0 is the shared-bus group and 1 is the memory-bus group. The set code together with the slot number forms the full register address. Both read ports are registered, so data appears one clock after the request. A read port keeps its last value until the next read on that port.

Top module: `xfer_regfile`

## Requirements
- R1: After reset every register holds zero, both read outputs are zero, and the index register is zero. An indirect access made before any index load therefore uses slot 0.
- R2: An external write (set code 0 or 1, slot, data) goes into the inbound register of that set. A datapath read of it, issued in cycle N, shows the data on `dp_rd_data` after the clock edge that ends cycle N.
- R3: A datapath write goes into the outbound register of the set it names. An external read of it shows the data on `ext_rd_data` one clock after the request.
- R4: Each of the four groups is separate. A write to one set does not change the same slot of the other set. A write to an outbound register does not change the inbound register at the same slot.
- R5: If an external write and a datapath read address the same inbound register in the same cycle, the read returns the data being written.
- R6: If a datapath write and an external read address the same outbound register in the same cycle, the read returns the value held before the write. A later read returns the new value.
- R7: When the indirect flag of a datapath access is 1, the index register picks the slot and the instruction slot field is ignored. This applies to reads and to writes.
- R8: `idx_ld` loads `idx_val` into the index register at the next edge. A load takes priority over any post-increment in the same cycle.
- R9: An indirect access with its post-increment flag set adds one to the index after the access, and slot DEPTH-1 is followed by slot 0. The index steps only once when both datapath ports request it in the same cycle. The post-increment flag has no effect on a direct access.
- R10: A read output keeps its value in cycles without a read on its port. This holds even while the register it came from is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_wr_en | input | 1 | External write to an inbound register |
| ext_wr_set | input | 1 | Set code of the external write (0 shared, 1 memory) |
| ext_wr_slot | input | IW | Slot of the external write |
| ext_wr_data | input | W | Data of the external write |
| ext_rd_en | input | 1 | External read of an outbound register |
| ext_rd_set | input | 1 | Set code of the external read |
| ext_rd_slot | input | IW | Slot of the external read |
| ext_rd_data | output | W | Registered external read data |
| dp_rd_en | input | 1 | Datapath operand read of an inbound register |
| dp_rd_set | input | 1 | Set code of the operand read |
| dp_rd_ind | input | 1 | Operand read uses the index register |
| dp_rd_pinc | input | 1 | Step the index after an indirect operand read |
| dp_rd_slot | input | IW | Instruction slot field for the operand read |
| dp_rd_data | output | W | Registered operand data |
| dp_wr_en | input | 1 | Datapath write of an outbound register |
| dp_wr_set | input | 1 | Set code of the result write |
| dp_wr_ind | input | 1 | Result write uses the index register |
| dp_wr_pinc | input | 1 | Step the index after an indirect result write |
| dp_wr_slot | input | IW | Instruction slot field for the result write |
| dp_wr_data | input | W | Result data |
| idx_ld | input | 1 | Load the index register |
| idx_val | input | IW | Value for the index load |

## Verification
The hardest situation to reach from the ports is the interaction of the shared index register with both datapath ports in a single cycle. In that cycle an indirect read and an indirect write both ask for a step, or a load arrives at the same time as a step. The only way to see the index is through the slot that the next indirect access picks. The stimulus therefore first writes distinct known values into neighbouring inbound slots. It then issues the conflicting cycle, and follows it with a plain indirect read whose returned value shows where the index landed. The same approach is used for the wrap from the last slot back to slot 0. The instruction slot field is set to a slot holding a different value, so that a wrong choice between direct and indirect addressing shows up in the data.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // set codes carried on every port
  localparam logic SET_SHARED = 1'b0;
  localparam logic SET_MEM    = 1'b1;
  localparam int   NUM_SETS   = 2;

  // advance a slot number by one, wrapping inside a group of 'depth' slots
  function automatic int unsigned next_slot(input int unsigned cur,
                                            input int unsigned depth);
    if (cur + 1 >= depth) return 0;
    return cur + 1;
  endfunction

  // the slot an access uses: index register when indirect, instruction field otherwise
  function automatic int unsigned pick_slot(input logic indirect,
                                            input int unsigned field,
                                            input int unsigned index);
    return indirect ? index : field;
  endfunction

endpackage

// File: rtl/xfer_index_unit.sv
module xfer_index_unit #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_ld,
  input  logic [IW-1:0] idx_val,
  input  logic          rd_en,
  input  logic          rd_ind,
  input  logic          rd_pinc,
  input  logic [IW-1:0] rd_field,
  input  logic          wr_en,
  input  logic          wr_ind,
  input  logic          wr_pinc,
  input  logic [IW-1:0] wr_field,
  output logic [IW-1:0] rd_slot,
  output logic [IW-1:0] wr_slot
);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_stepped;
  logic          rd_bump;
  logic          wr_bump;
  logic          idx_bump;   // some indirect access asked for a step
  logic          idx_wrap;   // that step goes from the last slot to slot 0

  assign rd_bump     = rd_en & rd_ind & rd_pinc;
  assign wr_bump     = wr_en & wr_ind & wr_pinc;
  assign idx_bump    = rd_bump | wr_bump;
  assign idx_stepped = IW'(xfer_pkg::next_slot(32'(idx_q), 32'(DEPTH)));
  assign idx_wrap    = idx_bump & (idx_stepped == '0);

  assign rd_slot = IW'(xfer_pkg::pick_slot(rd_ind, 32'(rd_field), 32'(idx_q)));
  assign wr_slot = IW'(xfer_pkg::pick_slot(wr_ind, 32'(wr_field), 32'(idx_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= '0;
    else if (idx_ld)   idx_q <= idx_val;
    else if (idx_bump) idx_q <= idx_stepped;
  end

  // R8: a load always wins
  p_idx_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> idx_q == $past(idx_val));

  // R9: a step from the last slot lands on slot 0
  p_idx_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_ld && idx_bump && idx_q == IW'(DEPTH-1)) |=> idx_q == '0);

  // R9: any other step adds exactly one, even with two requests
  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_ld && idx_bump && idx_q != IW'(DEPTH-1)) |=> idx_q == $past(idx_q) + 1'b1);

  // R9: without a load or an indirect step request the index holds
  p_idx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_ld && !idx_bump) |=> $stable(idx_q));

  // R7: an indirect access uses the index register
  p_ind_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ind) |-> rd_slot == idx_q);

endmodule

// File: rtl/xfer_bank.sv
module xfer_bank #(
  parameter int DEPTH  = 16,
  parameter int W      = 32,
  parameter bit BYPASS = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] slot_q [DEPTH];
  logic [W-1:0] rd_q;
  logic         same_slot;   // read and write address the same slot
  logic         hit_fwd;     // the write data is forwarded to the read

  assign same_slot = wr_en & rd_en & (wr_idx == rd_idx);
  assign hit_fwd   = BYPASS & same_slot;
  assign rd_data   = rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))     slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= hit_fwd ? wr_data : slot_q[rd_idx];
  end

  // R10: the output holds when there is no read
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  if (BYPASS) begin : g_fwd
    // R5: a same-cycle write is seen by the read
    p_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      same_slot |=> rd_data == $past(wr_data));
  end else begin : g_old
    // R6: a same-cycle write is not seen by the read
    p_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (same_slot && wr_data != slot_q[rd_idx]) |=> rd_data != $past(wr_data));
  end

endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_wr_en,
  input  logic          ext_wr_set,
  input  logic [IW-1:0] ext_wr_slot,
  input  logic [W-1:0]  ext_wr_data,
  input  logic          ext_rd_en,
  input  logic          ext_rd_set,
  input  logic [IW-1:0] ext_rd_slot,
  output logic [W-1:0]  ext_rd_data,
  input  logic          dp_rd_en,
  input  logic          dp_rd_set,
  input  logic          dp_rd_ind,
  input  logic          dp_rd_pinc,
  input  logic [IW-1:0] dp_rd_slot,
  output logic [W-1:0]  dp_rd_data,
  input  logic          dp_wr_en,
  input  logic          dp_wr_set,
  input  logic          dp_wr_ind,
  input  logic          dp_wr_pinc,
  input  logic [IW-1:0] dp_wr_slot,
  input  logic [W-1:0]  dp_wr_data,
  input  logic          idx_ld,
  input  logic [IW-1:0] idx_val
);

  logic [IW-1:0] eff_rd_slot;
  logic [IW-1:0] eff_wr_slot;
  logic [W-1:0]  in_rd  [xfer_pkg::NUM_SETS];
  logic [W-1:0]  out_rd [xfer_pkg::NUM_SETS];
  logic          dp_sel_q;
  logic          ext_sel_q;

  xfer_index_unit #(.DEPTH(DEPTH)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_ld   (idx_ld),
    .idx_val  (idx_val),
    .rd_en    (dp_rd_en),
    .rd_ind   (dp_rd_ind),
    .rd_pinc  (dp_rd_pinc),
    .rd_field (dp_rd_slot),
    .wr_en    (dp_wr_en),
    .wr_ind   (dp_wr_ind),
    .wr_pinc  (dp_wr_pinc),
    .wr_field (dp_wr_slot),
    .rd_slot  (eff_rd_slot),
    .wr_slot  (eff_wr_slot)
  );

  for (genvar s = 0; s < xfer_pkg::NUM_SETS; s++) begin : g_set
    // inbound: outside units write, datapath reads with forwarding
    xfer_bank #(.DEPTH(DEPTH), .W(W), .BYPASS(1'b1)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ext_wr_en && ext_wr_set == 1'(s)),
      .wr_idx  (ext_wr_slot),
      .wr_data (ext_wr_data),
      .rd_en   (dp_rd_en && dp_rd_set == 1'(s)),
      .rd_idx  (eff_rd_slot),
      .rd_data (in_rd[s])
    );
    // outbound: datapath writes, outside units read the old value on a clash
    xfer_bank #(.DEPTH(DEPTH), .W(W), .BYPASS(1'b0)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dp_wr_en && dp_wr_set == 1'(s)),
      .wr_idx  (eff_wr_slot),
      .wr_data (dp_wr_data),
      .rd_en   (ext_rd_en && ext_rd_set == 1'(s)),
      .rd_idx  (ext_rd_slot),
      .rd_data (out_rd[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_sel_q  <= xfer_pkg::SET_SHARED;
      ext_sel_q <= xfer_pkg::SET_SHARED;
    end else begin
      if (dp_rd_en)  dp_sel_q  <= dp_rd_set;
      if (ext_rd_en) ext_sel_q <= ext_rd_set;
    end
  end

  assign dp_rd_data  = in_rd[dp_sel_q];
  assign ext_rd_data = out_rd[ext_sel_q];

  // R10: ports hold between reads
  p_dp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_rd_en && !ext_wr_en) |=> $stable(dp_rd_data));
  p_ext_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_en |=> $stable(ext_rd_data));

endmodule

// File: tb/xfer_regfile_test.sv
module xfer_regfile_test;

  localparam int DEPTH = 16;
  localparam int W     = 32;
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_wr_en = 0, ext_wr_set = 0;
  logic [IW-1:0] ext_wr_slot = '0;
  logic [W-1:0]  ext_wr_data = '0;
  logic          ext_rd_en = 0, ext_rd_set = 0;
  logic [IW-1:0] ext_rd_slot = '0;
  logic [W-1:0]  ext_rd_data;
  logic          dp_rd_en = 0, dp_rd_set = 0, dp_rd_ind = 0, dp_rd_pinc = 0;
  logic [IW-1:0] dp_rd_slot = '0;
  logic [W-1:0]  dp_rd_data;
  logic          dp_wr_en = 0, dp_wr_set = 0, dp_wr_ind = 0, dp_wr_pinc = 0;
  logic [IW-1:0] dp_wr_slot = '0;
  logic [W-1:0]  dp_wr_data = '0;
  logic          idx_ld = 0;
  logic [IW-1:0] idx_val = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  xfer_regfile #(.DEPTH(DEPTH), .W(W)) uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // vector: kind[38:37] set[36] slot[35:32] data[31:0]
  // kind 0 ext write in, 1 dp read in (expect data), 2 dp write out, 3 ext read out (expect data)
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'd3,  32'hA1A1_0001},
    {2'd0, 1'b1, 4'd3,  32'hB2B2_0002},
    {2'd1, 1'b0, 4'd3,  32'hA1A1_0001},
    {2'd1, 1'b1, 4'd3,  32'hB2B2_0002},
    {2'd2, 1'b0, 4'd5,  32'hC3C3_0003},
    {2'd2, 1'b1, 4'd5,  32'hD4D4_0004},
    {2'd3, 1'b0, 4'd5,  32'hC3C3_0003},
    {2'd3, 1'b1, 4'd5,  32'hD4D4_0004},
    {2'd1, 1'b0, 4'd5,  32'h0000_0000},
    {2'd0, 1'b0, 4'd15, 32'hE5E5_0005},
    {2'd1, 1'b0, 4'd15, 32'hE5E5_0005},
    {2'd3, 1'b0, 4'd3,  32'h0000_0000}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    ext_wr_en = 0; ext_rd_en = 0; dp_rd_en = 0; dp_wr_en = 0; idx_ld = 0;
    dp_rd_ind = 0; dp_rd_pinc = 0; dp_wr_ind = 0; dp_wr_pinc = 0;
  endtask

  // inputs set before the call are sampled at the edge inside it
  task automatic step();
    @(negedge clk);
    idle_all();
  endtask

  task automatic ext_wr(input logic set, input int slot, input logic [W-1:0] d);
    ext_wr_en = 1; ext_wr_set = set; ext_wr_slot = IW'(slot); ext_wr_data = d;
    step();
  endtask

  task automatic dp_read(input logic set, input logic ind, input logic pinc, input int field);
    dp_rd_en = 1; dp_rd_set = set; dp_rd_ind = ind; dp_rd_pinc = pinc; dp_rd_slot = IW'(field);
    step();
  endtask

  task automatic ext_read(input logic set, input int slot);
    ext_rd_en = 1; ext_rd_set = set; ext_rd_slot = IW'(slot);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 dp_rd_data after reset", dp_rd_data, '0);
    check("R1 ext_rd_data after reset", ext_rd_data, '0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      kind = VEC[i][38:37];
      case (kind)
        2'd0: ext_wr(VEC[i][36], int'(VEC[i][35:32]), VEC[i][31:0]);
        2'd1: begin
          dp_read(VEC[i][36], 1'b0, 1'b0, int'(VEC[i][35:32]));
          check($sformatf("R2/R4 vector %0d", i), dp_rd_data, VEC[i][31:0]);
        end
        2'd2: begin
          dp_wr_en = 1; dp_wr_set = VEC[i][36]; dp_wr_slot = VEC[i][35:32];
          dp_wr_data = VEC[i][31:0];
          step();
        end
        default: begin
          ext_read(VEC[i][36], int'(VEC[i][35:32]));
          check($sformatf("R3/R4 vector %0d", i), ext_rd_data, VEC[i][31:0]);
        end
      endcase
    end

    // indirect addressing from the reset index
    ext_wr(1'b0, 0, 32'h0000_0011);
    ext_wr(1'b0, 1, 32'h0000_0022);
    ext_wr(1'b0, 2, 32'h0000_0033);
    dp_read(1'b0, 1'b1, 1'b0, 15);
    check("R1 index starts at 0 / R7 field ignored", dp_rd_data, 32'h0000_0011);

    // post-increment
    dp_read(1'b0, 1'b1, 1'b1, 15);
    check("R9 read before step uses slot 0", dp_rd_data, 32'h0000_0011);
    dp_read(1'b0, 1'b1, 1'b0, 15);
    check("R9 after step uses slot 1", dp_rd_data, 32'h0000_0022);

    // post-increment flag on a direct access is ignored
    dp_read(1'b0, 1'b0, 1'b1, 15);
    check("R9 direct read with step flag", dp_rd_data, 32'hE5E5_0005);
    dp_read(1'b0, 1'b1, 1'b0, 0);
    check("R9 direct access left index at 1", dp_rd_data, 32'h0000_0022);

    // load and wrap
    idx_ld = 1; idx_val = IW'(DEPTH-1);
    step();
    dp_read(1'b0, 1'b1, 1'b1, 0);
    check("R8 loaded index picks slot 15", dp_rd_data, 32'hE5E5_0005);
    dp_read(1'b0, 1'b1, 1'b0, 15);
    check("R9 wrap from last slot to slot 0", dp_rd_data, 32'h0000_0011);

    // load wins over a same-cycle step
    idx_ld = 1; idx_val = IW'(1);
    dp_read(1'b0, 1'b1, 1'b1, 9);
    check("R8 read in load cycle uses old index", dp_rd_data, 32'h0000_0011);
    dp_read(1'b0, 1'b1, 1'b0, 9);
    check("R8 load beats step", dp_rd_data, 32'h0000_0022);

    // both ports step in one cycle: index moves by one
    dp_wr_en = 1; dp_wr_set = 1'b1; dp_wr_ind = 1; dp_wr_pinc = 1; dp_wr_slot = IW'(9);
    dp_wr_data = 32'h0000_0077;
    dp_read(1'b0, 1'b1, 1'b1, 9);
    check("R9 dual-step cycle read uses slot 1", dp_rd_data, 32'h0000_0022);
    ext_read(1'b1, 1);
    check("R7 indirect write reached D-out slot 1", ext_rd_data, 32'h0000_0077);
    ext_read(1'b1, 9);
    check("R7 indirect write left field slot alone", ext_rd_data, 32'h0000_0000);
    dp_read(1'b0, 1'b1, 1'b0, 9);
    check("R9 two requests step the index once", dp_rd_data, 32'h0000_0033);

    // forwarding on inbound registers
    ext_wr_en = 1; ext_wr_set = 1'b0; ext_wr_slot = IW'(7); ext_wr_data = 32'h0000_0099;
    dp_read(1'b0, 1'b0, 1'b0, 7);
    check("R5 same-cycle write forwarded", dp_rd_data, 32'h0000_0099);

    // read-old on outbound registers
    dp_wr_en = 1; dp_wr_set = 1'b0; dp_wr_slot = IW'(5); dp_wr_data = 32'h0000_00AA;
    ext_read(1'b0, 5);
    check("R6 same-cycle read returns old value", ext_rd_data, 32'hC3C3_0003);
    ext_read(1'b0, 5);
    check("R6 later read returns new value", ext_rd_data, 32'h0000_00AA);

    // outputs hold without reads, even while the source changes
    ext_wr(1'b0, 7, 32'h0000_0123);
    step();
    check("R10 dp_rd_data holds", dp_rd_data, 32'h0000_0099);
    dp_wr_en = 1; dp_wr_set = 1'b0; dp_wr_slot = IW'(5); dp_wr_data = 32'h0000_0BBB;
    step();
    check("R10 ext_rd_data holds", ext_rd_data, 32'h0000_00AA);
    dp_read(1'b0, 1'b0, 1'b0, 7);
    check("R2 rewritten in-register visible", dp_rd_data, 32'h0000_0123);

    // reset clears stored contents
    rst_n = 0;
    step();
    rst_n = 1;
    dp_read(1'b0, 1'b0, 1'b0, 7);
    check("R1 in-register cleared by reset", dp_rd_data, '0);
    ext_read(1'b0, 5);
    check("R1 out-register cleared by reset", ext_rd_data, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule